// File: doc/BRIEF.md
# MSI Target Address Generator

This block turns an interrupt delivery request into a single message-signalled write. A request carries a hart index, a guest index, an interrupt identity and a privilege level. The block combines these with one of two software-programmed register pairs: one for machine level and one for supervisor level. From them it forms a 64-bit byte address and a 32-bit data word. It then offers both on a valid/ready write channel. The downstream bus may later report a completion error, and the block only raises a one-cycle flag for it.

Each register pair has a low word and a high word. The low word holds the lower 32 bits of a base page number. The high word holds the upper 12 base bits plus four packed layout fields: a group width, a group shift, a hart width and a hart shift. The hart index is split into a group part and a local part. Each part lands at its programmed place in the page number, and the guest index fills the lowest page bits. Setting the lock bit in a high word freezes that pair until reset. When the parameter `HAS_CHILD` is 0, the supervisor pair does not exist.

A three-state machine sequences each request. In IDLE, `req_ready` is high. A handshake captures the request and moves the machine to BUILD. In BUILD, the address and data are computed from the selected pair and registered, and the machine moves to ISSUE unconditionally. In ISSUE, `msg_valid` is high and stays high until `msg_ready`, and the machine then returns to IDLE.

Top module: `msi_addr_gen`

## Requirements
- R1: After reset, `req_ready` is 1, `msg_valid` is 0, `wr_err` is 0, and all four configuration words read as 0.
- R2: `cfg_sel` and `cfg_rsel` select the configuration word as follows: 0 is the machine low word, 1 is the machine high word, 2 is the supervisor low word and 3 is the supervisor high word. The high word is decoded as follows: bit 31 is the lock bit, bits 28:24 are the group shift GS, bits 22:20 are the hart shift HS, bits 18:16 are the group width GW, bits 15:12 are the hart width HW, and bits 11:0 are the upper base bits.
- R3: The page number is the OR of four terms: the 44-bit base ({high[11:0], low}), the group `(hart >> HW) & (2^GW-1)` shifted left by GS+12, the local hart `(hart & (2^HW-1))` shifted left by HS, and the guest `guest & (2^HS-1)`. `msg_addr` is the page number shifted left by 12.
- R4: `msg_data` is `req_eiid`, zero-extended to 32 bits.
- R5: A write to a high word stores only the bits of mask 0x9F77FFFF. All other bits read back as 0.
- R6: While bit 31 of a pair's high word is set, writes to either word of that pair leave both words unchanged.
- R7: When `req_super`=0, the machine pair is used and the guest index is treated as 0. When `req_super`=1, the supervisor pair is used with the request's guest index.
- R8: With `HAS_CHILD`=0, the supervisor words read as 0 and writes to them have no effect. The machine words remain writable.
- R9: From a request handshake until the cycle after `msg_valid && msg_ready`, `req_ready` is 0. While `msg_valid` is high without `msg_ready`, `msg_addr` and `msg_data` are held stable.
- R10: `msg_valid` is 0 in the first cycle after a request handshake and 1 in the second.
- R11: `wr_err` is 1 in the cycle after `resp_valid && resp_err` and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Word selected for writing |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rsel | input | 2 | Word selected for reading |
| cfg_rdata | output | 32 | Read data of the selected word |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request can be taken |
| req_super | input | 1 | 1 = supervisor level, 0 = machine level |
| req_hart | input | HART_W | Hart index |
| req_guest | input | GUEST_W | Guest index |
| req_eiid | input | EIID_W | Interrupt identity |
| msg_valid | output | 1 | Message write offered |
| msg_ready | input | 1 | Downstream accepts the write |
| msg_addr | output | 64 | Byte address of the message write |
| msg_data | output | 32 | Data of the message write |
| resp_valid | input | 1 | Write completion report |
| resp_err | input | 1 | Completion reported an error |
| wr_err | output | 1 | One-cycle error flag |

## Verification
The bench builds two instances.

The first, `u0`, uses a 14-bit hart index, a 6-bit guest index, an 11-bit identity and `HAS_CHILD`=1. These widths let the largest hart width of 15 swallow the whole hart index, which leaves a group of 0. They also let a narrow group width truncate an oversized group, and let a shift of 31 place the group near bit 62.

The second, `u1`, is the same except that `HAS_CHILD`=0. This makes the absent supervisor pair observable at the read port.

// File: rtl/msi_gen_pkg.sv
package msi_gen_pkg;

    localparam int unsigned PAGE_SHIFT = 12;
    localparam logic [31:0] HI_KEEP    = 32'h9F77_FFFF;

    typedef struct packed {
        logic        lock;
        logic [1:0]  pad_a;
        logic [4:0]  grp_shift;
        logic        pad_b;
        logic [2:0]  hrt_shift;
        logic        pad_c;
        logic [2:0]  grp_width;
        logic [3:0]  hrt_width;
        logic [11:0] base_top;
    } hi_word_t;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_BUILD = 2'd1,
        ST_ISSUE = 2'd2
    } gen_state_e;

endpackage

// File: rtl/msi_cfg_bank.sv
module msi_cfg_bank
    import msi_gen_pkg::*;
#(
    parameter bit HAS_CHILD = 1'b1
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        we,
    input  logic [1:0]  sel,
    input  logic [31:0] wdata,
    input  logic [1:0]  rsel,
    output logic [31:0] rdata,
    output logic [31:0] m_lo,
    output logic [31:0] m_hi,
    output logic [31:0] s_lo,
    output logic [31:0] s_hi
);
    localparam int unsigned NPAIR = 2;

    logic [31:0] lo_q [NPAIR];
    logic [31:0] hi_q [NPAIR];

    for (genvar p = 0; p < NPAIR; p++) begin : g_pair
        if (p == 0 || HAS_CHILD) begin : g_on
            logic [31:0] lo_r;
            logic [31:0] hi_r;
            logic        hit;

            assign hit = we && (sel[1] == 1'(p)) && !hi_r[31];

            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    lo_r <= '0;
                    hi_r <= '0;
                end else if (hit) begin
                    if (sel[0]) hi_r <= wdata & HI_KEEP;
                    else        lo_r <= wdata;
                end
            end

            assign lo_q[p] = lo_r;
            assign hi_q[p] = hi_r;
        end else begin : g_off
            assign lo_q[p] = '0;
            assign hi_q[p] = '0;
        end
    end

    assign rdata = rsel[0] ? hi_q[rsel[1]] : lo_q[rsel[1]];
    assign m_lo  = lo_q[0];
    assign m_hi  = hi_q[0];
    assign s_lo  = lo_q[1];
    assign s_hi  = hi_q[1];

endmodule

// File: rtl/msi_addr_calc.sv
module msi_addr_calc
    import msi_gen_pkg::*;
#(
    parameter int unsigned HART_W  = 14,
    parameter int unsigned GUEST_W = 6
) (
    input  logic [31:0]        lo_word,
    input  logic [31:0]        hi_word,
    input  logic [HART_W-1:0]  hart,
    input  logic [GUEST_W-1:0] guest,
    input  logic               use_guest,
    output logic [63:0]        addr
);
    hi_word_t    f;
    logic [63:0] hart64;
    logic [63:0] grp_part;
    logic [63:0] loc_part;
    logic [63:0] gst_part;
    logic [63:0] base_part;
    logic [63:0] page;
    logic [5:0]  grp_pos;

    always_comb begin
        f         = hi_word_t'(hi_word);
        hart64    = 64'(hart);
        grp_pos   = {1'b0, f.grp_shift} + 6'(PAGE_SHIFT);
        grp_part  = (hart64 >> f.hrt_width) & ((64'd1 << f.grp_width) - 64'd1);
        loc_part  = hart64 & ((64'd1 << f.hrt_width) - 64'd1);
        gst_part  = use_guest ? (64'(guest) & ((64'd1 << f.hrt_shift) - 64'd1)) : '0;
        base_part = {20'd0, f.base_top, lo_word};
        page      = base_part | (grp_part << grp_pos) | (loc_part << f.hrt_shift) | gst_part;
        addr      = page << PAGE_SHIFT;
    end

endmodule

// File: rtl/msi_issue_fsm.sv
module msi_issue_fsm
    import msi_gen_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req_valid,
    input  logic msg_ready,
    output logic req_ready,
    output logic msg_valid,
    output logic cap_en,
    output logic build_en
);
    gen_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (req_valid) state_d = ST_BUILD;
            ST_BUILD: state_d = ST_ISSUE;
            ST_ISSUE: if (msg_ready) state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        req_ready = 1'b0;
        msg_valid = 1'b0;
        cap_en    = 1'b0;
        build_en  = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                req_ready = 1'b1;
                cap_en    = req_valid;
            end
            ST_BUILD: build_en  = 1'b1;
            ST_ISSUE: msg_valid = 1'b1;
            default: ;
        endcase
    end

endmodule

// File: rtl/msi_addr_gen.sv
module msi_addr_gen
    import msi_gen_pkg::*;
#(
    parameter int unsigned HART_W    = 14,
    parameter int unsigned GUEST_W   = 6,
    parameter int unsigned EIID_W    = 11,
    parameter bit          HAS_CHILD = 1'b1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_we,
    input  logic [1:0]         cfg_sel,
    input  logic [31:0]        cfg_wdata,
    input  logic [1:0]         cfg_rsel,
    output logic [31:0]        cfg_rdata,
    input  logic               req_valid,
    output logic               req_ready,
    input  logic               req_super,
    input  logic [HART_W-1:0]  req_hart,
    input  logic [GUEST_W-1:0] req_guest,
    input  logic [EIID_W-1:0]  req_eiid,
    output logic               msg_valid,
    input  logic               msg_ready,
    output logic [63:0]        msg_addr,
    output logic [31:0]        msg_data,
    input  logic               resp_valid,
    input  logic               resp_err,
    output logic               wr_err
);
    logic [31:0] m_lo, m_hi, s_lo, s_hi;
    logic        cap_en, build_en;
    logic        sup_q;
    logic [HART_W-1:0]  hart_q;
    logic [GUEST_W-1:0] guest_q;
    logic [EIID_W-1:0]  eiid_q;
    logic [63:0] addr_calc;
    logic [63:0] addr_q;
    logic [31:0] data_q;
    logic        err_q;

    msi_cfg_bank #(.HAS_CHILD(HAS_CHILD)) u_bank (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (cfg_we),
        .sel   (cfg_sel),
        .wdata (cfg_wdata),
        .rsel  (cfg_rsel),
        .rdata (cfg_rdata),
        .m_lo  (m_lo),
        .m_hi  (m_hi),
        .s_lo  (s_lo),
        .s_hi  (s_hi)
    );

    msi_issue_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .msg_ready (msg_ready),
        .req_ready (req_ready),
        .msg_valid (msg_valid),
        .cap_en    (cap_en),
        .build_en  (build_en)
    );

    msi_addr_calc #(.HART_W(HART_W), .GUEST_W(GUEST_W)) u_calc (
        .lo_word   (sup_q ? s_lo : m_lo),
        .hi_word   (sup_q ? s_hi : m_hi),
        .hart      (hart_q),
        .guest     (guest_q),
        .use_guest (sup_q),
        .addr      (addr_calc)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sup_q   <= 1'b0;
            hart_q  <= '0;
            guest_q <= '0;
            eiid_q  <= '0;
        end else if (cap_en) begin
            sup_q   <= req_super;
            hart_q  <= req_hart;
            guest_q <= req_guest;
            eiid_q  <= req_eiid;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
            data_q <= '0;
        end else if (build_en) begin
            addr_q <= addr_calc;
            data_q <= 32'(eiid_q);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) err_q <= 1'b0;
        else        err_q <= resp_valid && resp_err;
    end

    assign msg_addr = addr_q;
    assign msg_data = data_q;
    assign wr_err   = err_q;

endmodule

// File: rtl/msi_addr_gen_chk.sv
module msi_addr_gen_chk #(
    parameter int unsigned EIID_W = 11
) (
    input logic        clk,
    input logic        rst_n,
    input logic        req_valid,
    input logic        req_ready,
    input logic        msg_valid,
    input logic        msg_ready,
    input logic [63:0] msg_addr,
    input logic [31:0] msg_data,
    input logic        resp_valid,
    input logic        resp_err,
    input logic        wr_err
);
    // R9: no new request taken while a message is offered
    a_r9_busy_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        msg_valid |-> !req_ready);

    // R9: a stalled message keeps its address and data
    a_r9_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_valid && !msg_ready) |=> (msg_valid && $stable(msg_addr) && $stable(msg_data)));

    // R10: two-cycle latency from acceptance to offer
    a_r10_latency: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> (!msg_valid ##1 msg_valid));

    // R11: flag follows an error completion
    a_r11_err_set: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && resp_err) |=> wr_err);

    // R11: flag stays low otherwise
    a_r11_err_clr: assert property (@(posedge clk) disable iff (!rst_n)
        !(resp_valid && resp_err) |=> !wr_err);

    // R4: data carries only identity bits
    a_r4_data_width: assert property (@(posedge clk) disable iff (!rst_n)
        msg_valid |-> ((msg_data >> EIID_W) == 32'd0));

endmodule

bind msi_addr_gen msi_addr_gen_chk #(.EIID_W(EIID_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .msg_valid  (msg_valid),
    .msg_ready  (msg_ready),
    .msg_addr   (msg_addr),
    .msg_data   (msg_data),
    .resp_valid (resp_valid),
    .resp_err   (resp_err),
    .wr_err     (wr_err)
);

// File: tb/sim_msi_addr_gen.sv
module sim_msi_addr_gen;

    typedef struct packed {
        logic [31:0] lo;
        logic [31:0] hi;
        logic [13:0] hart;
        logic [5:0]  guest;
        logic [10:0] eiid;
        logic        sup;
        logic [63:0] addr;
    } vec_t;

    localparam int NVEC = 6;
    localparam vec_t VECS [NVEC] = '{
        '{32'h0000_0000, 32'h0000_0000, 14'd5,      6'd3,  11'h007, 1'b1, 64'h0000_0000_0000_0000},
        '{32'h0008_0000, 32'h0432_2001, 14'd14,     6'd5,  11'h2A5, 1'b1, 64'h0000_1000_B001_5000},
        '{32'h0008_0000, 32'h0432_2001, 14'd14,     6'd5,  11'h7FF, 1'b0, 64'h0000_1000_B001_0000},
        '{32'h0000_0000, 32'h0001_1000, 14'd6,      6'h3F, 11'h001, 1'b1, 64'h0000_0000_0100_0000},
        '{32'h0000_0000, 32'h1F77_F000, 14'h3FFF,   6'h3F, 11'h400, 1'b1, 64'h0000_0001_FFFB_F000},
        '{32'hFFFF_FFFF, 32'h1403_4000, 14'h35,     6'd0,  11'h123, 1'b0, 64'h0000_3FFF_FFFF_F000}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_sel = '0;
    logic [31:0] cfg_wdata = '0;
    logic [1:0]  cfg_rsel = '0;
    logic [31:0] cfg_rdata, cfg_rdata1;
    logic        req_valid = 1'b0;
    logic        req_ready, req_ready1;
    logic        req_super = 1'b0;
    logic [13:0] req_hart = '0;
    logic [5:0]  req_guest = '0;
    logic [10:0] req_eiid = '0;
    logic        msg_valid, msg_valid1;
    logic        msg_ready = 1'b0;
    logic [63:0] msg_addr, msg_addr1;
    logic [31:0] msg_data, msg_data1;
    logic        resp_valid = 1'b0;
    logic        resp_err = 1'b0;
    logic        wr_err, wr_err1;

    int n_checks = 0;
    int n_errors = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    msi_addr_gen u0 (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .cfg_rsel(cfg_rsel), .cfg_rdata(cfg_rdata),
        .req_valid(req_valid), .req_ready(req_ready), .req_super(req_super),
        .req_hart(req_hart), .req_guest(req_guest), .req_eiid(req_eiid),
        .msg_valid(msg_valid), .msg_ready(msg_ready), .msg_addr(msg_addr),
        .msg_data(msg_data), .resp_valid(resp_valid), .resp_err(resp_err),
        .wr_err(wr_err)
    );

    msi_addr_gen #(.HAS_CHILD(1'b0)) u1 (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .cfg_rsel(cfg_rsel), .cfg_rdata(cfg_rdata1),
        .req_valid(1'b0), .req_ready(req_ready1), .req_super(1'b0),
        .req_hart(14'd0), .req_guest(6'd0), .req_eiid(11'd0),
        .msg_valid(msg_valid1), .msg_ready(1'b0), .msg_addr(msg_addr1),
        .msg_data(msg_data1), .resp_valid(1'b0), .resp_err(1'b0),
        .wr_err(wr_err1)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr_cfg(input logic [1:0] s, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = s; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic rd_cfg(input logic [1:0] s, output logic [31:0] d0, output logic [31:0] d1);
        @(negedge clk);
        cfg_rsel = s;
        #1;
        d0 = cfg_rdata;
        d1 = cfg_rdata1;
    endtask

    task automatic send(input logic sup, input logic [13:0] h, input logic [5:0] g,
                        input logic [10:0] e, output logic [63:0] a, output logic [31:0] d);
        @(negedge clk);
        chk("R9 ready before request", 64'(req_ready), 64'd1);
        req_valid = 1'b1; req_super = sup; req_hart = h; req_guest = g; req_eiid = e;
        @(negedge clk);
        req_valid = 1'b0;
        chk("R10 valid low in build cycle", 64'(msg_valid), 64'd0);
        chk("R9 ready low after accept", 64'(req_ready), 64'd0);
        @(negedge clk);
        chk("R10 valid high second cycle", 64'(msg_valid), 64'd1);
        a = msg_addr;
        d = msg_data;
        @(negedge clk);
        chk("R9 valid held while stalled", 64'(msg_valid), 64'd1);
        chk("R9 address held while stalled", msg_addr, a);
        chk("R9 ready low while stalled", 64'(req_ready), 64'd0);
        msg_ready = 1'b1;
        @(negedge clk);
        msg_ready = 1'b0;
        chk("R9 valid drops after accept", 64'(msg_valid), 64'd0);
        chk("R9 ready back after accept", 64'(req_ready), 64'd1);
    endtask

    task automatic check_reset_state();
        logic [31:0] r0, r1;
        chk("R1 req_ready", 64'(req_ready), 64'd1);
        chk("R1 msg_valid", 64'(msg_valid), 64'd0);
        chk("R1 wr_err", 64'(wr_err), 64'd0);
        for (int s = 0; s < 4; s++) begin
            rd_cfg(2'(s), r0, r1);
            chk("R1 config word zero", 64'(r0), 64'd0);
        end
    endtask

    initial begin
        #(8 * 150000);
        if (!finished) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("  Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        logic [63:0] a;
        logic [31:0] d, r0, r1;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        check_reset_state();

        // R8: instance without child domain
        wr_cfg(2'd2, 32'h1234_5678);
        wr_cfg(2'd3, 32'h0000_0ABC);
        rd_cfg(2'd2, r0, r1);
        chk("R8 absent low word reads 0", 64'(r1), 64'd0);
        rd_cfg(2'd3, r0, r1);
        chk("R8 absent high word reads 0", 64'(r1), 64'd0);
        chk("R2 present high word stored", 64'(r0), 64'h0000_0ABC);
        wr_cfg(2'd0, 32'h0000_BEEF);
        rd_cfg(2'd0, r0, r1);
        chk("R8 machine low word writable", 64'(r1), 64'h0000_BEEF);

        // R3 R4 R7: table of address layouts
        for (int i = 0; i < NVEC; i++) begin
            logic [1:0] base_sel;
            base_sel = VECS[i].sup ? 2'd2 : 2'd0;
            wr_cfg(base_sel, VECS[i].lo);
            wr_cfg(base_sel + 2'd1, VECS[i].hi);
            send(VECS[i].sup, VECS[i].hart, VECS[i].guest, VECS[i].eiid, a, d);
            chk("R3 address from layout", a, VECS[i].addr);
            chk("R4 data is identity", 64'(d), 64'(VECS[i].eiid));
        end

        // R7: pair selection by level
        wr_cfg(2'd0, 32'h0008_0000);
        wr_cfg(2'd1, 32'h0000_0000);
        wr_cfg(2'd2, 32'h0000_0123);
        wr_cfg(2'd3, 32'h0000_0000);
        send(1'b0, 14'd9, 6'd7, 11'd3, a, d);
        chk("R7 machine pair used", a, 64'h0000_0000_8000_0000);
        send(1'b1, 14'd9, 6'd7, 11'd3, a, d);
        chk("R7 supervisor pair used", a, 64'h0000_0000_0012_3000);

        // R11: completion error flag
        @(negedge clk);
        resp_valid = 1'b1; resp_err = 1'b1;
        @(negedge clk);
        resp_valid = 1'b0; resp_err = 1'b0;
        chk("R11 flag after error", 64'(wr_err), 64'd1);
        @(negedge clk);
        chk("R11 flag one cycle", 64'(wr_err), 64'd0);
        resp_valid = 1'b1; resp_err = 1'b0;
        @(negedge clk);
        resp_valid = 1'b0;
        chk("R11 no flag on clean completion", 64'(wr_err), 64'd0);

        // R5: reserved high-word bits dropped
        wr_cfg(2'd3, 32'h7FFF_FFFF);
        rd_cfg(2'd3, r0, r1);
        chk("R5 high word masked", 64'(r0), 64'h1F77_FFFF);

        // R6: lock freezes machine pair
        wr_cfg(2'd1, 32'h8000_1000);
        wr_cfg(2'd0, 32'h0000_DEAD);
        wr_cfg(2'd1, 32'h0000_0000);
        rd_cfg(2'd0, r0, r1);
        chk("R6 locked low word unchanged", 64'(r0), 64'h0008_0000);
        rd_cfg(2'd1, r0, r1);
        chk("R6 locked high word unchanged", 64'(r0), 64'h8000_1000);
        wr_cfg(2'd2, 32'h0000_0456);
        rd_cfg(2'd2, r0, r1);
        chk("R6 other pair still writable", 64'(r0), 64'h0000_0456);

        // R1: reset clears locks and registers
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        check_reset_state();

        finished = 1'b1;
        $display("  Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule